// File: doc/BRIEF.md
# Translation Cache with Recency Replacement

This block keeps a handful of recent virtual-to-physical page translations so that most address lookups skip the page table. It sits between a requester and a page table walker. Each lookup presents a 20-bit virtual page number (4 KiB pages, so the byte offset never enters the block). The number is compared against every stored entry in parallel. A match returns the stored 20-bit frame number in the same cycle. A mismatch starts a walk, holds the lookup open until the walker answers, and then stores the new translation.

Replacement tracks recency exactly. Every entry carries a small age, where zero marks the newest. The ages always form a permutation of 0 to N-1. Touching an entry, by a hit or by a fill, makes it the youngest and moves up only the entries that were younger than it. A fill goes to the lowest-numbered empty slot if one exists. Otherwise it replaces the oldest entry. A walker fault is passed back to the requester and nothing is stored. A flush input drops every entry at once.

Top module: `xlat_cache`

## Requirements
- R1: When an idle lookup matches a valid entry, `lk_done` and `lk_hit` are high in that same cycle, `lk_ppn` carries the stored frame, and no walk is requested.
- R2: When an idle lookup misses, `walk_req` rises on the next clock edge with `walk_vpn` equal to the looked-up page. It stays high until the cycle in which `walk_rsp_valid` is sampled. In that cycle `lk_done` is high, `lk_hit` is low and `lk_ppn` equals `walk_ppn`.
- R3: A hit makes the entry the most recent one. Entries that were more recent than it age by one, and the others keep their age.
- R4: A successful walk result goes into the lowest-indexed empty entry if there is one, or else replaces the least recently used entry. The four ages stay a permutation of 0..3 at all times.
- R5: A walker response with `walk_fault` high gives `lk_fault` high in the response cycle and leaves the stored entries unchanged.
- R6: A cycle with `flush` high invalidates every entry and resets the ages to the entry index order. A flush seen while a walk is outstanding still lets that walk answer the requester, but its result is not stored.
- R7: After reset, all entries are empty, and `lk_done` and `walk_req` are low.
- R8: At most one entry ever matches a given virtual page number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flush | input | 1 | Invalidate all entries |
| lk_valid | input | 1 | Lookup request, held until `lk_done` |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_done | output | 1 | Lookup answered this cycle |
| lk_hit | output | 1 | Answer came from a stored entry |
| lk_ppn | output | 20 | Physical frame number |
| lk_fault | output | 1 | Walker reported no valid mapping |
| walk_req | output | 1 | Walk request, held until response |
| walk_vpn | output | 20 | Page number to walk |
| walk_rsp_valid | input | 1 | Walker response strobe |
| walk_ppn | input | 20 | Frame number from walker |
| walk_fault | input | 1 | Walker fault flag |

## Verification
A corrupted age or a wrong victim choice does not show at once. It shows only when the cache is full and a fill evicts the wrong page. The next lookup of the page that should have survived then raises `walk_req` instead of answering as a hit, and a page that should have gone hits instead. The bench therefore fills all four entries, reorders them with hits, and then probes both the expected victim and the survivors right after each eviction. A missed flush or a fault that was stored anyway shows on the next lookup of the affected page as a hit that should have been a walk.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int XLAT_VPN_W = 20;
  localparam int XLAT_PPN_W = 20;
  localparam int XLAT_N_ENT = 4;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WALK = 1'b1
  } xlat_state_e;
endpackage

// File: rtl/xlat_entry_store.sv
module xlat_entry_store #(
  parameter int VPN_W = 20,
  parameter int PPN_W = 20,
  parameter int N_ENT = 4,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic [VPN_W-1:0] look_vpn,
  output logic [N_ENT-1:0] hit_vec,
  output logic [IDX_W-1:0] hit_idx,
  output logic [PPN_W-1:0] hit_ppn,
  output logic [N_ENT-1:0] valid_vec
);
  logic [N_ENT-1:0] valid_q, valid_d;
  logic [VPN_W-1:0] vpn_q [N_ENT];
  logic [PPN_W-1:0] ppn_q [N_ENT];
  logic             fill_we;

  assign fill_we = fill_en && !flush;

  always_comb begin
    valid_d = valid_q;
    if (flush) begin
      valid_d = '0;
    end else if (fill_en) begin
      valid_d[fill_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (fill_we) begin
      vpn_q[fill_idx] <= fill_vpn;
      ppn_q[fill_idx] <= fill_ppn;
    end
  end

  genvar g;
  generate
    for (g = 0; g < N_ENT; g++) begin : g_cmp
      assign hit_vec[g] = valid_q[g] && (vpn_q[g] == look_vpn);
    end
  endgenerate

  always_comb begin
    hit_ppn = '0;
    hit_idx = '0;
    for (int i = 0; i < N_ENT; i++) begin
      hit_ppn = hit_ppn | ({PPN_W{hit_vec[i]}} & ppn_q[i]);
      if (hit_vec[i]) hit_idx = IDX_W'(i);
    end
  end

  assign valid_vec = valid_q;

  // R8: never two matching entries
  p_single_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R6: flush empties the store
  p_flush_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_vec == '0));
endmodule

// File: rtl/xlat_age_tracker.sv
module xlat_age_tracker #(
  parameter int N_ENT = 4,
  localparam int AGE_W = $clog2(N_ENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             touch_en,
  input  logic [AGE_W-1:0] touch_idx,
  input  logic [N_ENT-1:0] valid_vec,
  output logic [AGE_W-1:0] victim_idx
);
  localparam logic [AGE_W-1:0] OLDEST = AGE_W'(N_ENT - 1);

  logic [AGE_W-1:0] age_q [N_ENT];
  logic [AGE_W-1:0] age_d [N_ENT];
  logic [AGE_W-1:0] touched_age;
  logic             free_found;

  assign touched_age = age_q[touch_idx];

  always_comb begin
    for (int i = 0; i < N_ENT; i++) begin
      age_d[i] = age_q[i];
      if (flush) begin
        age_d[i] = AGE_W'(i);
      end else if (touch_en) begin
        if (touch_idx == AGE_W'(i))        age_d[i] = '0;
        else if (age_q[i] < touched_age)   age_d[i] = age_q[i] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_ENT; i++) age_q[i] <= AGE_W'(i);
    end else begin
      for (int i = 0; i < N_ENT; i++) age_q[i] <= age_d[i];
    end
  end

  always_comb begin
    victim_idx = '0;
    free_found = 1'b0;
    for (int i = 0; i < N_ENT; i++) begin
      if (!free_found && !valid_vec[i]) begin
        victim_idx = AGE_W'(i);
        free_found = 1'b1;
      end
    end
    if (!free_found) begin
      for (int i = 0; i < N_ENT; i++) begin
        if (age_q[i] == OLDEST) victim_idx = AGE_W'(i);
      end
    end
  end

  // checker state: which ages are present, and who is youngest
  logic [N_ENT-1:0] age_seen;
  logic [AGE_W-1:0] youngest_idx;
  always_comb begin
    age_seen     = '0;
    youngest_idx = '0;
    for (int i = 0; i < N_ENT; i++) begin
      age_seen[age_q[i]] = 1'b1;
      if (age_q[i] == '0) youngest_idx = AGE_W'(i);
    end
  end

  // R4: ages remain a permutation
  p_age_perm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    age_seen == {N_ENT{1'b1}});

  // R3: touched entry becomes youngest
  p_touch_young_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (touch_en && !flush) |=> (youngest_idx == $past(touch_idx)));
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int VPN_W = XLAT_VPN_W,
  parameter int PPN_W = XLAT_PPN_W,
  parameter int N_ENT = XLAT_N_ENT,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_done,
  output logic             lk_hit,
  output logic [PPN_W-1:0] lk_ppn,
  output logic             lk_fault,
  output logic             walk_req,
  output logic [VPN_W-1:0] walk_vpn,
  input  logic             walk_rsp_valid,
  input  logic [PPN_W-1:0] walk_ppn,
  input  logic             walk_fault
);
  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  xlat_state_e      state_q, state_d;
  logic [VPN_W-1:0] wvpn_q, wvpn_d;
  logic             kill_q, kill_d;

  logic [N_ENT-1:0] hit_vec, valid_vec;
  logic [IDX_W-1:0] hit_idx, victim_idx, touch_idx;
  logic [PPN_W-1:0] hit_ppn;
  logic             any_hit, idle, hit_take, miss_start, rsp_take;
  logic             fill_en, touch_en;

  assign any_hit    = |hit_vec;
  assign idle       = (state_q == ST_IDLE);
  assign hit_take   = idle && lk_valid && any_hit;
  assign miss_start = idle && lk_valid && !any_hit;
  assign rsp_take   = (state_q == ST_WALK) && walk_rsp_valid;
  assign fill_en    = rsp_take && !walk_fault && !kill_q;
  assign touch_en   = hit_take || fill_en;
  assign touch_idx  = hit_take ? hit_idx : victim_idx;

  always_comb begin
    state_d = state_q;
    wvpn_d  = wvpn_q;
    kill_d  = kill_q;
    if (miss_start) begin
      state_d = ST_WALK;
      wvpn_d  = lk_vpn;
      kill_d  = 1'b0;
    end else begin
      if (rsp_take) state_d = ST_IDLE;
      if (flush)    kill_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      state_q <= ST_IDLE;
      kill_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      kill_q  <= kill_d;
    end
  end

  always_ff @(posedge clk) begin
    if (miss_start) wvpn_q <= wvpn_d;
  end

  xlat_entry_store #(
    .VPN_W(VPN_W), .PPN_W(PPN_W), .N_ENT(N_ENT)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_sync),
    .flush     (flush),
    .fill_en   (fill_en),
    .fill_idx  (victim_idx),
    .fill_vpn  (wvpn_q),
    .fill_ppn  (walk_ppn),
    .look_vpn  (lk_vpn),
    .hit_vec   (hit_vec),
    .hit_idx   (hit_idx),
    .hit_ppn   (hit_ppn),
    .valid_vec (valid_vec)
  );

  xlat_age_tracker #(
    .N_ENT(N_ENT)
  ) u_ages (
    .clk        (clk),
    .rst_n      (rst_sync),
    .flush      (flush),
    .touch_en   (touch_en),
    .touch_idx  (touch_idx),
    .valid_vec  (valid_vec),
    .victim_idx (victim_idx)
  );

  assign lk_done  = hit_take || rsp_take;
  assign lk_hit   = hit_take;
  assign lk_ppn   = hit_take ? hit_ppn : walk_ppn;
  assign lk_fault = rsp_take && walk_fault;
  assign walk_req = (state_q == ST_WALK);
  assign walk_vpn = wvpn_q;

  // R1: a hit never leads into a walk
  p_hit_no_walk_r1: assert property (@(posedge clk) disable iff (!rst_sync)
    (lk_valid && lk_hit) |=> !walk_req);

  // R2: request held with a steady page number until answered
  p_walk_hold_r2: assert property (@(posedge clk) disable iff (!rst_sync)
    (walk_req && !walk_rsp_valid) |=> (walk_req && $stable(walk_vpn)));

  // R5: a faulting response stores nothing
  p_fault_no_fill_r5: assert property (@(posedge clk) disable iff (!rst_sync)
    (walk_req && walk_rsp_valid && walk_fault && !flush) |=> $stable(valid_vec));
endmodule

// File: tb/xlat_cache_bench.sv
module xlat_cache_bench;
  logic        clk = 1'b0;
  logic        rst_n, flush, lk_valid;
  logic [19:0] lk_vpn;
  logic        lk_done, lk_hit, lk_fault, walk_req;
  logic [19:0] lk_ppn, walk_vpn;
  logic        walk_rsp_valid, walk_fault;
  logic [19:0] walk_ppn;

  always #10 clk = ~clk;

  xlat_cache u_xlat_cache (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .lk_valid(lk_valid), .lk_vpn(lk_vpn),
    .lk_done(lk_done), .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_fault(lk_fault),
    .walk_req(walk_req), .walk_vpn(walk_vpn),
    .walk_rsp_valid(walk_rsp_valid), .walk_ppn(walk_ppn), .walk_fault(walk_fault)
  );

  typedef struct packed {
    logic        hit;
    logic        fault;
    logic [19:0] ppn;
  } exp_t;

  exp_t        exp_q[$];
  string       tag_q[$];
  logic [19:0] mru[$];
  int          n_chk = 0;
  int          n_err = 0;
  bit          finished = 0;
  logic [19:0] cur_vpn;

  function automatic logic [19:0] map_of(logic [19:0] v);
    return v ^ 20'hA5C3F;
  endfunction
  function automatic logic faults(logic [19:0] v);
    return v[19:16] == 4'hF;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // monitor: pops expected answers as the design delivers them
  always @(negedge clk) begin
    if (rst_n && lk_done) begin
      if (exp_q.size() == 0) begin
        check("R1 unexpected answer", 32'd1, 32'd0);
      end else begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({t, " hit"},   {31'd0, lk_hit},   {31'd0, e.hit});
        check({t, " fault"}, {31'd0, lk_fault}, {31'd0, e.fault});
        check({t, " ppn"},   {12'd0, lk_ppn},   {12'd0, e.ppn});
      end
    end
  end

  // page walker model: answers two cycles after seeing the request
  initial begin
    walk_rsp_valid = 1'b0;
    walk_ppn       = '0;
    walk_fault     = 1'b0;
    forever begin
      @(posedge clk); #3;
      if (rst_n && walk_req) begin
        check("R2 walk page", {12'd0, walk_vpn}, {12'd0, cur_vpn});
        @(posedge clk); #1;
        check("R2 request held", {31'd0, walk_req}, 32'd1);
        @(posedge clk); #2;
        walk_rsp_valid = 1'b1;
        walk_ppn       = map_of(walk_vpn);
        walk_fault     = faults(walk_vpn);
        @(posedge clk); #2;
        walk_rsp_valid = 1'b0;
      end
    end
  end

  task automatic lookup(logic [19:0] v, string tag, bit flush_mid = 0);
    bit   in_model;
    exp_t e;
    int   pos;
    in_model = 0;
    pos = -1;
    foreach (mru[i]) if (mru[i] == v) begin in_model = 1; pos = i; end
    e.hit   = in_model;
    e.fault = in_model ? 1'b0 : faults(v);
    e.ppn   = map_of(v);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(posedge clk); #2;
    cur_vpn  = v;
    lk_valid = 1'b1;
    lk_vpn   = v;
    if (flush_mid && !in_model) begin
      @(posedge clk); #2 flush = 1'b1;
      @(posedge clk); #2 flush = 1'b0;
    end
    do @(negedge clk); while (!lk_done);
    @(posedge clk); #2;
    lk_valid = 1'b0;
    if (flush_mid) begin
      mru.delete();
    end else if (in_model) begin
      mru.delete(pos);
      mru.push_front(v);
    end else if (!faults(v)) begin
      mru.push_front(v);
      if (mru.size() > 4) void'(mru.pop_back());
    end
  endtask

  task automatic flush_all();
    @(posedge clk); #2 flush = 1'b1;
    @(posedge clk); #2 flush = 1'b0;
    mru.delete();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; flush = 1'b0; lk_valid = 1'b0; lk_vpn = '0; cur_vpn = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R7 done idle", {31'd0, lk_done}, 32'd0);
    check("R7 walk idle", {31'd0, walk_req}, 32'd0);

    lookup(20'h00011, "R2 first miss");
    lookup(20'h00011, "R1 repeat hit");
    lookup(20'h00022, "R2 miss");
    lookup(20'h00033, "R2 miss");
    lookup(20'h00044, "R4 fourth fill");
    lookup(20'h00011, "R4 free slots used");
    lookup(20'h00022, "R4 free slots used");
    lookup(20'h00033, "R4 free slots used");
    lookup(20'h00044, "R4 free slots used");
    lookup(20'h00011, "R3 refresh oldest");
    lookup(20'h00055, "R4 evict lru");
    lookup(20'h00033, "R3 survivor hit");
    lookup(20'h00022, "R4 evicted page walks");
    lookup(20'h00044, "R4 next lru evicted");
    lookup(20'h00055, "R3 recent kept");
    lookup(20'hF0007, "R5 fault");
    lookup(20'hF0007, "R5 fault not stored");
    lookup(20'h00055, "R5 nothing evicted");
    lookup(20'hEFFFF, "R8 high page");
    lookup(20'hEFFFF, "R8 high page hit");
    flush_all();
    lookup(20'h00055, "R6 after flush");
    lookup(20'h00066, "R6 flush during walk", 1);
    lookup(20'h00066, "R6 killed fill");
    lookup(20'h00055, "R6 cleared by mid flush");
    lookup(20'h00055, "R1 hit after refill");

    repeat (4) @(posedge clk);
    check("R1 all answers seen", exp_q.size(), 32'd0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule